// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense and Status

This block watches the input levels of a GPIO port and turns them into interrupt requests. Each pin has its own trigger setting, built from three configuration bit planes: a sense plane that picks edge or level detection, a polarity plane that picks the active direction or level, and an any-edge plane that makes an edge pin fire on both transitions. Edge events are held in a raw status register until software clears them by writing ones to a clear address. Level pins are not held: their raw status bit shows the active level, one clock late.

A per-pin enable stops a pin from recording anything. A separate per-pin mask hides a pin from the masked status view and from the single interrupt output, but its raw status keeps recording. The pin inputs are expected to be synchronized, and debounced if needed, before they reach this block. Software reaches every register through a simple 32-bit register port. Writes take one cycle and reads are combinational.

Top module: `gpio_irq_sense`

## Requirements
- R1: After a clock edge with `rst_n` low, the enable, mask, sense, polarity and any-edge registers are all zero, the raw status is zero and `irq_out` is low.
- R2: An enabled pin with sense bit 0, any-edge bit 0 and polarity bit 0 sets its raw status bit in the cycle after it is first sampled high following a low sample. A high-to-low change does not set it.
- R3: An enabled pin with sense bit 0, any-edge bit 0 and polarity bit 1 sets its raw status bit only after a high-to-low change.
- R4: An enabled pin with sense bit 0 and any-edge bit 1 sets its raw status bit after either transition, whatever its polarity bit.
- R5: For a pin with sense bit 1, the raw status bit after each clock edge equals enable AND (pin level XOR polarity bit) as sampled at that edge. The bit is not held, so polarity 0 means active high and polarity 1 means active low.
- R6: A pin whose enable bit is 0 never changes its raw status bit from 0 to 1.
- R7: Writing to the clear address (0x1C) clears the raw status bit of every edge-mode pin whose data bit is 1. Data bits that are 0 leave their pins unchanged, and level-mode pins are not affected.
- R8: If an edge event and a clear of the same pin land on the same clock edge, the raw status bit ends up set.
- R9: A mask bit of 1 removes the pin from the masked status and from `irq_out`, while its raw status bit still records events.
- R10: `irq_out` is high exactly when some raw status bit is 1 and its mask bit is 0.
- R11: The register map is: enable 0x00, mask 0x04, sense 0x08, polarity 0x0C, any-edge 0x10 (all read/write), raw status 0x14 (read only), masked status 0x18 (read only), clear 0x1C (write only, reads as 0). Unused upper data bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block at its default width of 32 pins. This puts every bit position of the 32-bit register port in use, including bit 31, so the readback, clear and mask paths are exercised across the whole data word. The directed phases give separate pins separate trigger settings at the same time, so one pin's events can be checked for leakage into its neighbours. The long random phase then mixes clears, configuration rewrites and pin toggles, which lets same-cycle collisions of a clear and an edge appear on many different pins.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// gpio_irq_pkg
// Shared constants for the GPIO interrupt sense block: register port widths
// and the register byte offsets. Assumes a word-aligned 5-bit address.
package gpio_irq_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SENSE   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_POLAR   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_ANYEDGE = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_MASKED  = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 5'h1C;
endpackage

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
// gpio_irq_cfg
// Holds the per-pin configuration planes (enable, mask, sense, polarity,
// any-edge) and decodes clear writes into a one-cycle clear vector.
// Assumes NUM_PINS <= BUS_W; data bits above NUM_PINS are dropped.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] sense_q,
    output logic [NUM_PINS-1:0] polar_q,
    output logic [NUM_PINS-1:0] anyedge_q,
    output logic [NUM_PINS-1:0] clr_bits
);
    logic [NUM_PINS-1:0] wbits;

    // Purpose: narrow the write data to the pin count.
    always_comb begin : narrow_wdata
        wbits = wdata[NUM_PINS-1:0];
    end

    // Purpose: load the addressed configuration plane on a write.
    always_ff @(posedge clk) begin : cfg_store
        if (!rst_n) begin
            en_q      <= '0;
            mask_q    <= '0;
            sense_q   <= '0;
            polar_q   <= '0;
            anyedge_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_ENABLE:  en_q      <= wbits;
                OFS_MASK:    mask_q    <= wbits;
                OFS_SENSE:   sense_q   <= wbits;
                OFS_POLAR:   polar_q   <= wbits;
                OFS_ANYEDGE: anyedge_q <= wbits;
                default:     ;
            endcase
        end
    end

    // Purpose: produce the write-one-to-clear vector for this cycle.
    always_comb begin : clear_decode
        clr_bits = (wr_en && (addr == OFS_CLEAR)) ? wbits : '0;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// gpio_irq_detect
// Per-pin trigger logic. Keeps the previous pin sample and reports, for
// the current cycle, an edge hit on edge-mode pins and the active level
// on level-mode pins. Assumes pin_in is already synchronous to clk.
// The previous-sample register follows pin_in in every cycle, reset
// included, so no false edge appears when reset is released.
module gpio_irq_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] en,
    input  logic [NUM_PINS-1:0] sense,
    input  logic [NUM_PINS-1:0] polar,
    input  logic [NUM_PINS-1:0] anyedge,
    output logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] level_act
);
    logic [NUM_PINS-1:0] pin_prev;

    // Purpose: remember the previous pin sample.
    always_ff @(posedge clk) begin : prev_sample
        pin_prev <= pin_in;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise_p;
        logic fall_p;
        logic dir_hit;

        // Purpose: classify the transition seen on this pin.
        always_comb begin : classify
            rise_p  = pin_in[p] & ~pin_prev[p];
            fall_p  = ~pin_in[p] & pin_prev[p];
            dir_hit = polar[p] ? fall_p : rise_p;
        end

        // Purpose: qualify the transition by enable and trigger mode.
        always_comb begin : qualify
            edge_hit[p]  = en[p] & ~sense[p] &
                           (anyedge[p] ? (rise_p | fall_p) : dir_hit);
            level_act[p] = en[p] & sense[p] & (pin_in[p] ^ polar[p]);
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
// gpio_irq_status
// Raw status storage and masking. Edge-mode bits are held until cleared,
// and a new event beats a clear of the same pin. Level-mode bits take the
// active level each cycle and are not held. The combined request is the
// OR of the unmasked raw bits.
module gpio_irq_status #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] edge_hit,
    input  logic [NUM_PINS-1:0] level_act,
    input  logic [NUM_PINS-1:0] sense,
    input  logic [NUM_PINS-1:0] clr_bits,
    input  logic [NUM_PINS-1:0] mask,
    output logic [NUM_PINS-1:0] raw_q,
    output logic [NUM_PINS-1:0] masked,
    output logic                irq
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_bit
        // Purpose: update one raw status bit.
        always_ff @(posedge clk) begin : raw_bit
            if (!rst_n)
                raw_q[p] <= 1'b0;
            else if (sense[p])
                raw_q[p] <= level_act[p];
            else if (edge_hit[p])
                raw_q[p] <= 1'b1;
            else if (clr_bits[p])
                raw_q[p] <= 1'b0;
        end
    end

    // Purpose: apply the mask and merge into the single request.
    always_comb begin : mask_merge
        masked = raw_q & ~mask;
        irq    = |masked;
    end
endmodule

// File: rtl/gpio_irq_sense.sv
`timescale 1ns/1ps
// gpio_irq_sense
// Top of the GPIO interrupt sense block: configuration registers,
// per-pin trigger detection, status storage and register readback.
// Assumes synchronized pin inputs and a single-cycle register write.
module gpio_irq_sense
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BUS_W-1:0]    reg_wdata,
    output logic [BUS_W-1:0]    reg_rdata,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] cfg_en;
    logic [NUM_PINS-1:0] cfg_mask;
    logic [NUM_PINS-1:0] cfg_sense;
    logic [NUM_PINS-1:0] cfg_polar;
    logic [NUM_PINS-1:0] cfg_anyedge;
    logic [NUM_PINS-1:0] clr_bits;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] level_act;
    logic [NUM_PINS-1:0] raw_q;
    logic [NUM_PINS-1:0] masked;

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en_q     (cfg_en),
        .mask_q   (cfg_mask),
        .sense_q  (cfg_sense),
        .polar_q  (cfg_polar),
        .anyedge_q(cfg_anyedge),
        .clr_bits (clr_bits)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk      (clk),
        .pin_in   (pin_in),
        .en       (cfg_en),
        .sense    (cfg_sense),
        .polar    (cfg_polar),
        .anyedge  (cfg_anyedge),
        .edge_hit (edge_hit),
        .level_act(level_act)
    );

    gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .level_act(level_act),
        .sense    (cfg_sense),
        .clr_bits (clr_bits),
        .mask     (cfg_mask),
        .raw_q    (raw_q),
        .masked   (masked),
        .irq      (irq_out)
    );

    // Purpose: return the addressed register, zero-extended to the bus.
    always_comb begin : readback
        reg_rdata = '0;
        case (reg_addr)
            OFS_ENABLE:  reg_rdata[NUM_PINS-1:0] = cfg_en;
            OFS_MASK:    reg_rdata[NUM_PINS-1:0] = cfg_mask;
            OFS_SENSE:   reg_rdata[NUM_PINS-1:0] = cfg_sense;
            OFS_POLAR:   reg_rdata[NUM_PINS-1:0] = cfg_polar;
            OFS_ANYEDGE: reg_rdata[NUM_PINS-1:0] = cfg_anyedge;
            OFS_RAW:     reg_rdata[NUM_PINS-1:0] = raw_q;
            OFS_MASKED:  reg_rdata[NUM_PINS-1:0] = masked;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
`timescale 1ns/1ps
// gpio_irq_sense_chk
// Temporal checks on the interrupt sense block, bound to its top module.
module gpio_irq_sense_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_in,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] raw_q,
    input logic [NUM_PINS-1:0] cfg_en,
    input logic [NUM_PINS-1:0] cfg_mask,
    input logic [NUM_PINS-1:0] cfg_sense,
    input logic [NUM_PINS-1:0] cfg_polar,
    input logic [NUM_PINS-1:0] cfg_anyedge,
    input logic [NUM_PINS-1:0] clr_bits,
    input logic [NUM_PINS-1:0] edge_hit
);
    logic [NUM_PINS-1:0] pin_d;
    logic [NUM_PINS-1:0] want_set;

    // Purpose: keep the checker's own copy of the previous pin sample.
    always_ff @(posedge clk) begin : chk_prev
        pin_d <= pin_in;
    end

    // Purpose: edge-mode pins that must be set after this edge (R2, R3, R4).
    always_comb begin : chk_want
        want_set = cfg_en & ~cfg_sense &
                   ((cfg_anyedge & (pin_in ^ pin_d)) |
                    (~cfg_anyedge & ~cfg_polar & pin_in & ~pin_d) |
                    (~cfg_anyedge & cfg_polar & ~pin_in & pin_d));
    end

    // R2, R3 and R4: a qualifying transition sets its raw bit
    assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (want_set != '0) |=> ((raw_q & $past(want_set)) == $past(want_set)));

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(cfg_sense)) ==
                  $past(cfg_en & cfg_sense & (pin_in ^ cfg_polar))));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(cfg_en) & ~$past(raw_q)) == '0));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits != '0) |=> ((raw_q & $past(clr_bits & ~edge_hit & ~cfg_sense)) == '0));

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & edge_hit) != '0) |=>
            ((raw_q & $past(clr_bits & edge_hit)) == $past(clr_bits & edge_hit)));

    assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & ~cfg_mask) == '0) |-> !irq_out);

    assert_unmasked_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & ~cfg_mask) != '0) |-> irq_out);
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .irq_out    (irq_out),
    .raw_q      (raw_q),
    .cfg_en     (cfg_en),
    .cfg_mask   (cfg_mask),
    .cfg_sense  (cfg_sense),
    .cfg_polar  (cfg_polar),
    .cfg_anyedge(cfg_anyedge),
    .clr_bits   (clr_bits),
    .edge_hit   (edge_hit)
);

// File: tb/gpio_irq_sense_bench.sv
`timescale 1ns/1ps
// Bench for gpio_irq_sense: a behavioural per-pin model advanced on each
// clock edge, with irq_out and reg_rdata compared after every edge.
module gpio_irq_sense_bench;
    localparam int NP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic        wr = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // model state
    bit [31:0] m_en = '0, m_mask = '0, m_sense = '0, m_pol = '0, m_any = '0;
    bit [31:0] m_raw = '0, m_prev = '0;

    gpio_irq_sense #(.NUM_PINS(NP)) u_gpio_irq_sense (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_wr(wr),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    always #5 clk = ~clk;

    // model: advance one cycle on each rising edge
    always @(posedge clk) begin
        bit [31:0] nxt;
        bit [31:0] clr;
        nxt = m_raw;
        clr = (wr && addr == 5'h1C) ? wdata : 32'h0;
        if (!rst_n) begin
            m_en = 0; m_mask = 0; m_sense = 0; m_pol = 0; m_any = 0; nxt = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                bit hit;
                hit = 1'b0;
                if (m_sense[i]) begin
                    nxt[i] = m_en[i] && (pins[i] != m_pol[i]);
                end else begin
                    if (m_en[i]) begin
                        if (m_any[i])      hit = (pins[i] != m_prev[i]);
                        else if (m_pol[i]) hit = m_prev[i] && !pins[i];
                        else               hit = !m_prev[i] && pins[i];
                    end
                    if (hit) nxt[i] = 1'b1;
                    else if (clr[i]) nxt[i] = 1'b0;
                end
            end
            if (wr) begin
                case (addr)
                    5'h00: m_en = wdata;
                    5'h04: m_mask = wdata;
                    5'h08: m_sense = wdata;
                    5'h0C: m_pol = wdata;
                    5'h10: m_any = wdata;
                    default: ;
                endcase
            end
        end
        m_raw = nxt;
        m_prev = pins;
    end

    function automatic bit [31:0] exp_rdata(input bit [4:0] a);
        case (a)
            5'h00: return m_en;
            5'h04: return m_mask;
            5'h08: return m_sense;
            5'h0C: return m_pol;
            5'h10: return m_any;
            5'h14: return m_raw;
            5'h18: return m_raw & ~m_mask;
            default: return 32'h0;
        endcase
    endfunction

    // compare after every edge, once outputs have settled
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            bit e_irq;
            bit [31:0] e_rd;
            e_irq = ((m_raw & ~m_mask) != 0);   // R10
            e_rd  = exp_rdata(addr);            // R11
            vectors++;
            if (irq !== e_irq) begin
                miscompares++;
                $display("FAIL %s irq_out actual %0b expected %0b at %0t", cur_req, irq, e_irq, $time);
            end
            vectors++;
            if (rdata !== e_rd) begin
                miscompares++;
                $display("FAIL %s rdata[%h] actual %h expected %h at %0t", cur_req, addr, rdata, e_rd, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input bit [4:0] a, input bit [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_pins(input bit [31:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic look(input bit [4:0] a);
        @(negedge clk);
        addr = a;
    endtask

    // watchdog
    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state, all registers read
        cur_req = "R1";
        step(3);
        for (int a = 0; a < 8; a++) look(5'(a * 4));
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) look(5'(a * 4));

        // R11: readback of each plane with distinct patterns
        cur_req = "R11";
        wr_reg(5'h04, 32'hA5A5_0F0F); look(5'h04);
        wr_reg(5'h08, 32'h8000_0001); look(5'h08);
        wr_reg(5'h0C, 32'h1234_5678); look(5'h0C);
        wr_reg(5'h10, 32'hFEDC_BA98); look(5'h10);
        wr_reg(5'h1C, 32'hFFFF_FFFF); look(5'h1C);
        look(5'h14); look(5'h18);
        wr_reg(5'h04, 0); wr_reg(5'h08, 0); wr_reg(5'h0C, 0); wr_reg(5'h10, 0);

        // pin0 rising, pin1 falling, pin2 any (pol 1), pin3 level high,
        // pin4 level low, pin5 disabled, pin6 masked rising
        wr_reg(5'h08, 32'h18);
        wr_reg(5'h0C, 32'h16);
        wr_reg(5'h10, 32'h04);
        wr_reg(5'h04, 32'h40);
        wr_reg(5'h00, 32'h5F);
        look(5'h14);

        cur_req = "R2";
        set_pins(32'h61); step(2); look(5'h18);
        cur_req = "R3";
        set_pins(32'h02); step(2);
        set_pins(32'h00); step(2);
        cur_req = "R4";
        set_pins(32'h04); step(2);
        wr_reg(5'h1C, 32'h04);
        set_pins(32'h00); step(2);
        cur_req = "R5";
        set_pins(32'h08); step(2);
        set_pins(32'h10); step(2);
        set_pins(32'h00); step(2);
        cur_req = "R6";
        set_pins(32'h20); step(2); set_pins(32'h00); step(2);
        cur_req = "R9";
        look(5'h14); look(5'h18);

        // R7: zero bits no effect, then clear set bits; level pins ignore it
        cur_req = "R7";
        wr_reg(5'h1C, 32'h0); look(5'h14);
        set_pins(32'h00);
        wr_reg(5'h1C, 32'h47); look(5'h14);
        look(5'h18);

        // R8: edge and clear on pin0 on the same edge
        cur_req = "R8";
        @(negedge clk);
        pins = 32'h01; wr = 1'b1; addr = 5'h1C; wdata = 32'h01;
        @(negedge clk);
        wr = 1'b0; addr = 5'h14;
        step(2);

        // R10: mask all then unmask
        cur_req = "R10";
        wr_reg(5'h04, 32'hFFFF_FFFF); look(5'h18);
        wr_reg(5'h04, 32'h0); look(5'h18);

        // random mix over all pins
        cur_req = "R8";
        wr_reg(5'h00, 32'hFFFF_FFFF);
        for (int k = 0; k < 4000; k++) begin
            bit [31:0] r;
            @(negedge clk);
            pins = pins ^ ($urandom & $urandom & $urandom);
            r = $urandom;
            addr = 5'((r[2:0]) * 4);
            wr = 1'b0;
            if (r[7:4] == 0) begin
                wr = 1'b1; addr = 5'h1C; wdata = $urandom;
            end else if (r[11:8] == 0) begin
                wr = 1'b1; wdata = $urandom;
                addr = 5'(($urandom % 5) * 4);
            end
        end
        @(negedge clk);
        wr = 1'b0;
        step(2);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule